// File: doc/BRIEF.md
# Self-ID Sequence Parser and Validator

After a bus reset, every node on a serial bus sends one or more 32-bit self-ID quadlets, and the link layer receives them all back to back in one buffer. This block takes that buffer as a valid/ready quadlet stream and splits it into one sequence per node. It follows the more-packets flag in bit 0 to decide which quadlets belong together. It checks that each continuation quadlet is marked as extended and numbered in order, and it rejects chains that are too long or cut short by the end of the buffer.

For each well-formed sequence the block raises a one-cycle done strobe. Alongside the strobe it presents the node's header fields from the first quadlet, the sequence length, and a decoded vector of 2-bit port states. A malformed sequence raises an error strobe instead. After an error the block discards the rest of the buffer and waits for the next one. A buffer that holds nothing is sent as a single empty beat and produces a no-data strobe.

Top module: `selfid_seq_parser`

## Requirements
- R1: While reset is held, `in_ready` and all three strobes are low. In the first cycle after reset is released, `in_ready` is high and stays high.
- R2: A quadlet that opens a sequence with bit 0 clear closes a one-quadlet node. In the cycle after it is accepted, `done_o` is high and `seq_len_o` is 1. The header ports then show these bits of that quadlet: `phy_id_o` bits 29:24, `link_active_o` bit 22, `gap_count_o` bits 21:16, `speed_o` bits 15:14, `contender_o` bit 11, `power_class_o` bits 10:8, `init_reset_o` bit 1.
- R3: A quadlet with bit 0 set chains the next accepted quadlet into the same node. `done_o` rises in the cycle after the first quadlet with bit 0 clear is accepted, with `seq_len_o` equal to the number of quadlets in the node.
- R4: Each continuation quadlet must have bit 23 set, and its bits 22:20 must equal its position minus one (0 for the second quadlet, 1 for the third, 2 for the fourth). Otherwise `err_o` pulses in the cycle after that quadlet is accepted.
- R5: A node holds at most 4 quadlets. Bit 0 set on the fourth quadlet is an error.
- R6: Bit 0 set on the quadlet that carries `in_last` is an error.
- R7: Every quadlet must carry the value 2 in bits 31:30. Any other value is an error.
- R8: Port p (0 to 26) occupies `port_status_o[2p+1:2p]`. It is read from quadlet (p+5)/8 of the node, at bits s+1:s with s = 16 - 2*((p+5) mod 8). A port whose quadlet index is not below `seq_len_o` reads as 0. The values are 0 absent, 1 not connected, 2 to parent, 3 to child.
- R9: An empty beat (`in_empty` high) accepted between nodes pulses `nodata_o`. Accepted in the middle of a node, it pulses `err_o`.
- R10: After an error on a beat without `in_last`, later beats cause no strobe up to and including the next beat with `in_last` or `in_empty`. The beat after that is parsed as the start of a new node.
- R11: Each strobe lasts one cycle, at most one of `done_o`, `err_o` and `nodata_o` is high in any cycle, and no strobe rises in a cycle after no beat was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A beat is offered |
| in_ready | output | 1 | The block accepts the beat |
| in_data | input | 32 | Self-ID quadlet |
| in_last | input | 1 | This quadlet is the last of the buffer |
| in_empty | input | 1 | This beat carries no quadlet and marks an empty buffer |
| done_o | output | 1 | One-cycle strobe: a valid node sequence was closed |
| err_o | output | 1 | One-cycle strobe: protocol error |
| nodata_o | output | 1 | One-cycle strobe: empty buffer |
| seq_len_o | output | 3 | Quadlets in the closed node |
| phy_id_o | output | 6 | Node's physical ID |
| link_active_o | output | 1 | Link-active flag |
| gap_count_o | output | 6 | Gap count |
| speed_o | output | 2 | Speed code |
| contender_o | output | 1 | Contender flag |
| power_class_o | output | 3 | Power class |
| init_reset_o | output | 1 | Node started the reset |
| port_status_o | output | 54 | 27 two-bit port states, port 0 in the low bits |

## Verification
Every strobe and every header, length and port field is registered. Each is therefore due exactly one clock edge after the edge that accepts the beat that causes it, and it is valid only while its strobe is high. The bench drives each beat at a falling edge and holds it for one rising edge. It samples the outputs at the next falling edge and compares them there with values from its own model of the parser. It also samples every idle cycle between beats and requires all strobes to be low, so a late or repeated strobe counts as a failure.

// File: rtl/selfid_pkg.sv
package selfid_pkg;

  localparam logic [1:0] KIND_SELF_ID = 2'd2;

  typedef enum logic [0:0] {PS_RUN, PS_DRAIN} parse_state_t;

  typedef struct packed {
    logic [5:0] phy_id;
    logic       link_active;
    logic [5:0] gap_count;
    logic [1:0] speed;
    logic       contender;
    logic [2:0] power_class;
    logic       init_reset;
  } node_hdr_t;

  // Number of 2-bit port slots a node of n quadlets can describe.
  function automatic int port_capacity(input int n);
    return 8 * n - 5;
  endfunction

  // Quadlet within the node that holds port p.
  function automatic int port_quad_idx(input int p);
    return (p + 5) / 8;
  endfunction

  // Low bit of port p's field inside its quadlet.
  function automatic int port_shift(input int p);
    return 16 - 2 * ((p + 5) % 8);
  endfunction

endpackage

// File: rtl/selfid_chain_check.sv
module selfid_chain_check #(
  parameter int MAX_QUADS = 4,
  localparam int PW = $clog2(MAX_QUADS)
) (
  input  logic [1:0]    kind,
  input  logic          ext_flag,
  input  logic [2:0]    ext_seq,
  input  logic          more,
  input  logic [PW-1:0] pos,
  input  logic          last,
  output logic          bad,
  output logic          closes
);
  import selfid_pkg::*;

  logic [31:0] want_seq;
  logic        kind_bad, ext_bad, overrun;

  always_comb begin
    want_seq = 32'(pos) - 32'd1;
    kind_bad = (kind != KIND_SELF_ID);
    ext_bad  = (pos != '0) && (!ext_flag || (32'(ext_seq) != want_seq));
    overrun  = more && ((32'(pos) == MAX_QUADS - 1) || last);
    bad      = kind_bad || ext_bad || overrun;
    closes   = !more;
  end

endmodule

// File: rtl/selfid_port_unpack.sv
module selfid_port_unpack #(
  parameter int MAX_QUADS = 4,
  localparam int PORTS = 8 * MAX_QUADS - 5,
  localparam int CW    = $clog2(MAX_QUADS + 1)
) (
  input  logic [MAX_QUADS-1:0][31:0] quads,
  input  logic [CW-1:0]              len,
  output logic [2*PORTS-1:0]         status
);
  import selfid_pkg::*;

  logic unused_quad_bits;
  assign unused_quad_bits = ^quads;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam int QI = port_quad_idx(p);
    localparam int SH = port_shift(p);
    assign status[2*p +: 2] = (32'(QI) < 32'(len)) ? quads[QI][SH +: 2] : 2'b00;
  end

endmodule

// File: rtl/selfid_seq_parser.sv
module selfid_seq_parser #(
  parameter int MAX_QUADS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [31:0]                           in_data,
  input  logic                                  in_last,
  input  logic                                  in_empty,
  output logic                                  done_o,
  output logic                                  err_o,
  output logic                                  nodata_o,
  output logic [$clog2(MAX_QUADS+1)-1:0]        seq_len_o,
  output logic [5:0]                            phy_id_o,
  output logic                                  link_active_o,
  output logic [5:0]                            gap_count_o,
  output logic [1:0]                            speed_o,
  output logic                                  contender_o,
  output logic [2:0]                            power_class_o,
  output logic                                  init_reset_o,
  output logic [2*(8*MAX_QUADS-5)-1:0]          port_status_o
);
  import selfid_pkg::*;

  localparam int PW    = $clog2(MAX_QUADS);
  localparam int CW    = $clog2(MAX_QUADS + 1);
  localparam int PORTS = port_capacity(MAX_QUADS);

  parse_state_t              state_q;
  logic [PW-1:0]             pos_q;
  logic [MAX_QUADS-1:0][31:0] quads_q;
  logic [CW-1:0]             len_q;
  logic                      ready_q, done_q, err_q, nodata_q;
  node_hdr_t                 hdr;

  // Named internal events, used by the bound checker.
  logic accept_w, bad_w, closes_w, draining_w;

  assign accept_w   = in_valid && in_ready;
  assign draining_w = (state_q == PS_DRAIN);

  selfid_chain_check #(.MAX_QUADS(MAX_QUADS)) u_chain (
    .kind     (in_data[31:30]),
    .ext_flag (in_data[23]),
    .ext_seq  (in_data[22:20]),
    .more     (in_data[0]),
    .pos      (pos_q),
    .last     (in_last),
    .bad      (bad_w),
    .closes   (closes_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= PS_RUN;
      pos_q    <= '0;
      quads_q  <= '0;
      len_q    <= '0;
      ready_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      nodata_q <= 1'b0;
    end else begin
      ready_q  <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      nodata_q <= 1'b0;
      if (accept_w) begin
        case (state_q)
          PS_DRAIN: begin
            if (in_last || in_empty) state_q <= PS_RUN;
          end
          default: begin
            if (in_empty) begin
              pos_q <= '0;
              if (pos_q == '0) nodata_q <= 1'b1;
              else             err_q    <= 1'b1;
            end else begin
              quads_q[pos_q] <= in_data;
              if (bad_w) begin
                err_q <= 1'b1;
                pos_q <= '0;
                if (!in_last) state_q <= PS_DRAIN;
              end else if (closes_w) begin
                done_q <= 1'b1;
                len_q  <= CW'(pos_q) + CW'(1);
                pos_q  <= '0;
              end else begin
                pos_q <= pos_q + PW'(1);
              end
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    hdr.phy_id      = quads_q[0][29:24];
    hdr.link_active = quads_q[0][22];
    hdr.gap_count   = quads_q[0][21:16];
    hdr.speed       = quads_q[0][15:14];
    hdr.contender   = quads_q[0][11];
    hdr.power_class = quads_q[0][10:8];
    hdr.init_reset  = quads_q[0][1];
  end

  selfid_port_unpack #(.MAX_QUADS(MAX_QUADS)) u_ports (
    .quads  (quads_q),
    .len    (len_q),
    .status (port_status_o)
  );

  assign in_ready      = ready_q;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign nodata_o      = nodata_q;
  assign seq_len_o     = len_q;
  assign phy_id_o      = hdr.phy_id;
  assign link_active_o = hdr.link_active;
  assign gap_count_o   = hdr.gap_count;
  assign speed_o       = hdr.speed;
  assign contender_o   = hdr.contender;
  assign power_class_o = hdr.power_class;
  assign init_reset_o  = hdr.init_reset;

  localparam int UNUSED_PORTS = PORTS;

endmodule

// File: rtl/selfid_seq_checker.sv
module selfid_seq_checker #(
  parameter int MAX_QUADS = 4,
  localparam int CW    = $clog2(MAX_QUADS + 1),
  localparam int PORTS = 8 * MAX_QUADS - 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic [31:0]        in_data,
  input logic               in_empty,
  input logic               done_o,
  input logic               err_o,
  input logic               nodata_o,
  input logic [CW-1:0]      seq_len_o,
  input logic [2*PORTS-1:0] port_status_o,
  input logic               accept_w,
  input logic               draining_w
);

  logic unused_data_bits;
  assign unused_data_bits = ^in_data[29:1];

  // R11: strobes never overlap
  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o, nodata_o}));

  // R11: a strobe only follows an accepted beat
  assert_strobe_needs_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o || nodata_o) |-> $past(accept_w));

  // R3: done follows an accepted quadlet whose chain flag is clear
  assert_done_on_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(accept_w && !in_empty && !in_data[0]));

  // R3: length reported with done lies in 1..MAX_QUADS
  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (seq_len_o != '0 && 32'(seq_len_o) <= MAX_QUADS));

  // R7: a wrong packet kind on a parsed quadlet gives an error
  assert_kind_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept_w && !draining_w && !in_empty && in_data[31:30] != 2'd2) |-> err_o);

  // R9: no-data only after an accepted empty beat
  assert_nodata_on_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nodata_o |-> $past(accept_w && in_empty));

  // R10: a beat dropped while draining raises no strobe
  assert_drain_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(draining_w) |-> !(done_o || err_o || nodata_o));

  // R8: a one-quadlet node reports only ports 0..2
  assert_ports_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && seq_len_o == CW'(1)) |-> (port_status_o[2*PORTS-1:6] == '0));

  // R1: ready stays high once out of reset
  assert_ready_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready);

endmodule

bind selfid_seq_parser selfid_seq_checker #(.MAX_QUADS(MAX_QUADS)) u_seq_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .in_data       (in_data),
  .in_empty      (in_empty),
  .done_o        (done_o),
  .err_o         (err_o),
  .nodata_o      (nodata_o),
  .seq_len_o     (seq_len_o),
  .port_status_o (port_status_o),
  .accept_w      (accept_w),
  .draining_w    (draining_w)
);

// File: tb/test_selfid_seq_parser.sv
`timescale 1ns/1ps
module test_selfid_seq_parser;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_empty = 1'b0;
  logic        done_o, err_o, nodata_o;
  logic [2:0]  seq_len_o;
  logic [5:0]  phy_id_o, gap_count_o;
  logic        link_active_o, contender_o, init_reset_o;
  logic [1:0]  speed_o;
  logic [2:0]  power_class_o;
  logic [53:0] port_status_o;

  always #4 clk = ~clk;  // 125 MHz

  selfid_seq_parser i_selfid_seq_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_empty(in_empty),
    .done_o(done_o), .err_o(err_o), .nodata_o(nodata_o), .seq_len_o(seq_len_o),
    .phy_id_o(phy_id_o), .link_active_o(link_active_o), .gap_count_o(gap_count_o),
    .speed_o(speed_o), .contender_o(contender_o), .power_class_o(power_class_o),
    .init_reset_o(init_reset_o), .port_status_o(port_status_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model state
  int          m_pos = 0;
  bit          m_drain = 0;
  logic [31:0] m_q [4];
  bit          e_done, e_err, e_nodata;
  int          e_len;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R8: port p is slot p+5 counted in 2-bit steps down from bit 17 of each quadlet
  function automatic logic [53:0] exp_ports(input int len);
    logic [53:0] v = '0;
    for (int p = 0; p < 27; p++) begin
      int slot = p + 5;
      int k = slot / 8;
      int off = slot % 8;
      if (k < len) v[2*p +: 2] = m_q[k][17 - 2*off -: 2];
    end
    return v;
  endfunction

  function automatic logic [19:0] exp_hdr();
    logic [31:0] q = m_q[0];
    return {q[29:24], q[22], q[21:16], q[15:14], q[11], q[10:8], q[1]};
  endfunction

  task automatic model_step(input logic [31:0] d, input bit l, input bit e);
    bit bad;
    e_done = 0; e_err = 0; e_nodata = 0;
    if (m_drain) begin
      if (l || e) m_drain = 0;
    end else if (e) begin
      if (m_pos == 0) e_nodata = 1; else e_err = 1;
      m_pos = 0;
    end else begin
      bad = (d[31:30] != 2'd2) ||
            (m_pos > 0 && (!d[23] || int'(d[22:20]) != m_pos - 1)) ||
            (d[0] && (m_pos == 3 || l));
      m_q[m_pos] = d;
      if (bad) begin
        e_err = 1; m_pos = 0; m_drain = !l;
      end else if (!d[0]) begin
        e_done = 1; e_len = m_pos + 1; m_pos = 0;
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic send(input logic [31:0] d, input bit l, input bit e, input string req);
    in_valid = 1; in_data = d; in_last = l; in_empty = e;
    model_step(d, l, e);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0; in_empty = 0; in_data = $urandom;
    check(req, "strobes{done,err,nodata}", {61'd0, done_o, err_o, nodata_o},
          {61'd0, e_done, e_err, e_nodata});
    if (e_done) begin
      check("R3", "seq_len", 64'(seq_len_o), 64'(e_len));
      check("R2", "header", 64'({phy_id_o, link_active_o, gap_count_o, speed_o,
                                 contender_o, power_class_o, init_reset_o}), 64'(exp_hdr()));
      check("R8", "port_status", 64'(port_status_o), 64'(exp_ports(e_len)));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R11", "idle strobes", {61'd0, done_o, err_o, nodata_o}, 64'd0);
    end
  endtask

  function automatic logic [31:0] mk_quad(input int k, input bit more);
    logic [31:0] q = $urandom;
    q[31:30] = 2'd2;
    if (k > 0) begin
      q[23] = 1'b1;
      q[22:20] = 3'(k - 1);
    end
    q[0] = more;
    return q;
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240617));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", 64'(in_ready), 64'd0);
    check("R1", "strobes in reset", {61'd0, done_o, err_o, nodata_o}, 64'd0);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "ready after reset", 64'(in_ready), 64'd1);

    // R2: single-quadlet node
    send(32'h8A5B_C906, 1, 0, "R2");
    idle(1);
    // R3 / R8: full four-quadlet node
    send(mk_quad(0, 1), 0, 0, "R3");
    send(mk_quad(1, 1), 0, 0, "R3");
    send(mk_quad(2, 1), 0, 0, "R3");
    send(mk_quad(3, 0), 1, 0, "R8");
    // R5: fifth quadlet requested, then R10: drain and recover
    send(mk_quad(0, 1), 0, 0, "R3");
    send(mk_quad(1, 1), 0, 0, "R3");
    send(mk_quad(2, 1), 0, 0, "R3");
    send(mk_quad(3, 1), 0, 0, "R5");
    send(mk_quad(0, 0), 0, 0, "R10");
    send(mk_quad(0, 0), 1, 0, "R10");
    send(mk_quad(0, 0), 1, 0, "R10");
    // R4: wrong sequence number, then missing extended bit
    send(mk_quad(0, 1), 0, 0, "R3");
    send(mk_quad(2, 0), 1, 0, "R4");
    begin
      logic [31:0] q = mk_quad(1, 0);
      q[23] = 1'b0;
      send(mk_quad(0, 1), 0, 0, "R3");
      send(q, 1, 0, "R4");
    end
    // R7: wrong kind on first and on continuation quadlet
    begin
      logic [31:0] q = mk_quad(0, 0);
      q[31:30] = 2'd0;
      send(q, 1, 0, "R7");
      q = mk_quad(1, 0);
      q[31:30] = 2'd3;
      send(mk_quad(0, 1), 0, 0, "R3");
      send(q, 1, 0, "R7");
    end
    // R6: chain flag on the buffer's last quadlet
    send(mk_quad(0, 1), 1, 0, "R6");
    // R9: empty buffer, then empty beat inside a node
    send(32'h0, 0, 1, "R9");
    send(mk_quad(0, 1), 0, 0, "R3");
    send(32'h0, 0, 1, "R9");
    idle(2);

    // random buffers with occasional faults
    for (int b = 0; b < 400; b++) begin
      if ($urandom % 8 == 0) begin
        send(32'h0, 0, 1, "R9");
      end else begin
        int nodes = 1 + $urandom % 5;
        for (int n = 0; n < nodes; n++) begin
          int len = 1 + $urandom % 4;
          for (int k = 0; k < len; k++) begin
            logic [31:0] q = mk_quad(k, k < len - 1);
            if ($urandom % 12 == 0) begin
              case ($urandom % 6)
                0: q[31] = ~q[31];
                1: q[30] = ~q[30];
                2: q[23] = ~q[23];
                3: q[22] = ~q[22];
                4: q[20] = ~q[20];
                default: q[0] = ~q[0];
              endcase
            end
            send(q, (n == nodes - 1) && (k == len - 1), 0, "R4");
            if ($urandom % 3 == 0) idle($urandom % 3);
          end
        end
      end
    end
    idle(2);
    finish_run();
  end

endmodule